// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the word address for a synchronous, pipelined burst memory. On a rising clock edge it can capture a fresh base address from the address bus when one of two active-low load strobes is asserted. The processor-side strobe outranks the controller-side strobe. After a load, an active-low advance input walks the two least significant address bits through a four-beat burst. The upper bits stay where they were loaded.

A static order select chooses the burst order. In interleaved order, beat n carries the start bits XOR n. In linear order, beat n carries the start bits plus n, modulo four. After the fourth beat the sequence wraps back to the start address. The chip-select qualification is captured with every load, and a burst only advances while a selected load is live. The memory array, the data path and the write controls sit outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and on the first edges after its release with no strobe asserted, addr_out is zero and burst_live is 0.
- R2: proc_stb_n low with chip_sel high loads addr_in into addr_out on that clock edge and sets burst_live to 1. The burst restarts at beat 0.
- R3: When proc_stb_n and ctrl_stb_n are both low, only the processor strobe takes effect. With chip_sel low, the cycle therefore leaves addr_out and burst_live unchanged, even though the controller strobe alone would have loaded.
- R4: With linear_mode 0 (interleaved), each advance moves the low two bits to start XOR n, where n is the beat index 0..3.
- R5: With linear_mode 1 (linear), each advance moves the low two bits to (start + n) mod 4.
- R6: The advance after beat 3 returns the low two bits to the start value, in both orders.
- R7: With neither strobe asserted and adv_n high, addr_out holds its value.
- R8: With neither strobe asserted, bits ADDR_W-1..2 of addr_out never change.
- R9: ctrl_stb_n low with proc_stb_n high always loads addr_in, restarts the burst at beat 0, and sets burst_live to the value of chip_sel. This holds in the middle of a burst too.
- R10: With neither strobe asserted and burst_live 0, adv_n low does not change addr_out.
- R11: proc_stb_n low with chip_sel low is ignored: addr_out and burst_live keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | ADDR_W | Base address bus |
| proc_stb_n | input | 1 | Processor load strobe, active low, high priority |
| ctrl_stb_n | input | 1 | Controller load strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| linear_mode | input | 1 | Burst order select: 1 linear, 0 interleaved (static) |
| chip_sel | input | 1 | Chip-enable qualification, active high |
| addr_out | output | ADDR_W | Registered current address |
| burst_live | output | 1 | A selected burst is in progress |

## Verification
Directed bursts start from odd and even base values in both orders. Because XOR and addition give different beats for starts 1 and 3, these runs tell the interleaved order from the linear order and also expose the wrap. Separate directed cycles cover each strobe pairing against chip_sel. The case of both strobes with chip deselected is the one that shows whether the priority is right, since the controller strobe alone would load there. A long random run then mixes loads, holds, advances and deselects, comparing every cycle against a reference model in the bench. This catches counter slips and upper-bit corruption across burst boundaries.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              proc_stb_n,
  input  logic              ctrl_stb_n,
  input  logic              adv_n,
  input  logic              linear_mode,
  input  logic              chip_sel,
  output logic [ADDR_W-1:0] addr_out,
  output logic              burst_live
);
  localparam int LOW_W = 2;

  logic [ADDR_W-1:0] addr_q;
  logic [LOW_W-1:0]  start_q, beat_q;
  logic              live_q;

  wire proc_ld = !proc_stb_n && chip_sel;
  wire ctrl_ld = proc_stb_n && !ctrl_stb_n;
  wire step    = proc_stb_n && ctrl_stb_n && !adv_n && live_q;

  wire [LOW_W-1:0] beat_nx = beat_q + 1'b1;
  wire [LOW_W-1:0] low_nx  = linear_mode ? LOW_W'(start_q + beat_nx) : (start_q ^ beat_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      start_q <= '0;
      beat_q  <= '0;
      live_q  <= 1'b0;
    end else if (proc_ld || ctrl_ld) begin
      addr_q  <= addr_in;
      start_q <= addr_in[LOW_W-1:0];
      beat_q  <= '0;
      live_q  <= chip_sel;
    end else if (step) begin
      beat_q              <= beat_nx;
      addr_q[LOW_W-1:0]   <= low_nx;
    end
  end

  assign addr_out   = addr_q;
  assign burst_live = live_q;

  AST_PROC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_stb_n && chip_sel) |=> (addr_out == $past(addr_in)) && burst_live); // R2
  AST_PROC_DESEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_stb_n && !chip_sel) |=> $stable(addr_out) && $stable(burst_live)); // R11
  AST_BOTH_STROBES_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_stb_n && !ctrl_stb_n && !chip_sel) |=> $stable(addr_out)); // R3
  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_stb_n && !ctrl_stb_n) |=> (addr_out == $past(addr_in)) && (burst_live == $past(chip_sel))); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_stb_n && ctrl_stb_n && adv_n) |=> $stable(addr_out)); // R7
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_stb_n && ctrl_stb_n) |=> $stable(addr_out[ADDR_W-1:LOW_W])); // R8
  AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_stb_n && ctrl_stb_n && !burst_live) |=> $stable(addr_out)); // R10
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          proc_stb_n = 1'b1, ctrl_stb_n = 1'b1, adv_n = 1'b1;
  logic          linear_mode = 1'b0, chip_sel = 1'b0;
  logic [AW-1:0] addr_out;
  logic          burst_live;

  int checks = 0, fails = 0;

  logic [AW-1:0] m_addr = '0;
  logic [1:0]    m_start = '0, m_beat = '0;
  logic          m_live = 1'b0;

  always #10 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) i_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .proc_stb_n(proc_stb_n),
    .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n), .linear_mode(linear_mode),
    .chip_sel(chip_sel), .addr_out(addr_out), .burst_live(burst_live));

  function automatic logic [1:0] beat_low(logic [1:0] s, logic [1:0] n, logic lin);
    logic [2:0] sum;
    sum = {1'b0, s} + {1'b0, n};
    return lin ? sum[1:0] : (s ^ n);
  endfunction

  task automatic check(string tag);
    checks++;
    if (addr_out !== m_addr || burst_live !== m_live) begin
      fails++;
      $display("FAIL %s: addr=%h live=%b expected addr=%h live=%b", tag, addr_out, burst_live, m_addr, m_live);
    end
  endtask

  task automatic cyc(logic [AW-1:0] a, logic ps, logic cs, logic av, logic lin, logic sel, string tag);
    @(negedge clk);
    addr_in = a; proc_stb_n = ps; ctrl_stb_n = cs; adv_n = av; linear_mode = lin; chip_sel = sel;
    if (!ps) begin
      if (sel) begin m_addr = a; m_start = a[1:0]; m_beat = 0; m_live = 1; end
    end else if (!cs) begin
      m_addr = a; m_start = a[1:0]; m_beat = 0; m_live = sel;
    end else if (!av && m_live) begin
      m_beat = m_beat + 1;
      m_addr[1:0] = beat_low(m_start, m_beat, lin);
    end
    @(posedge clk); #1;
    check(tag);
  endtask

  initial begin
    #100000000;
    fails++;
    $display("FAIL watchdog: run hung");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    void'($urandom(32'd1234));
    #5; check("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    cyc('0, 1, 1, 0, 0, 1, "R1 after reset, advance idle");
    cyc('0, 1, 1, 1, 0, 1, "R1 after reset");
    // interleaved from start 1: 1,0,3,2,1
    cyc(18'h2A5F1 & 18'h3FFFD, 0, 1, 1, 0, 1, "R2 proc load");
    for (int i = 0; i < 3; i++) cyc('0, 1, 1, 0, 0, 0, "R4 interleaved step");
    cyc('0, 1, 1, 0, 0, 0, "R6 interleaved wrap");
    cyc('0, 1, 1, 1, 0, 0, "R7 hold");
    // linear from start 3: 3,0,1,2,3
    cyc(18'h15553, 1, 0, 1, 1, 1, "R9 ctrl load");
    for (int i = 0; i < 3; i++) cyc('0, 1, 1, 0, 1, 1, "R5 linear step");
    cyc('0, 1, 1, 0, 1, 1, "R6 linear wrap");
    cyc('0, 1, 1, 0, 1, 1, "R5 linear second pass");
    cyc(18'h3FFFC, 1, 0, 1, 1, 1, "R9 ctrl restart mid burst");
    cyc(18'h0ABC0, 0, 1, 1, 1, 0, "R11 proc deselected ignored");
    cyc(18'h0ABC0, 0, 0, 1, 1, 0, "R3 both strobes deselected");
    cyc(18'h0ABC0, 0, 0, 1, 1, 1, "R3 both strobes selected");
    cyc(18'h01112, 1, 0, 1, 0, 0, "R9 ctrl load deselected");
    cyc('0, 1, 1, 0, 0, 1, "R10 no step when idle");
    for (int i = 0; i < 4000; i++) begin
      logic ps, cs, av, sel;
      a   = AW'($urandom);
      ps  = ($urandom % 5) != 0;
      cs  = ($urandom % 5) != 0;
      av  = ($urandom % 3) == 0;
      sel = ($urandom % 4) != 0;
      cyc(a, ps, cs, av, i[9], sel,
          !ps ? (sel ? "R2 random" : "R11 random") : !cs ? "R9 random" :
          av ? "R7 random" : (m_live ? (i[9] ? "R5 random" : "R4 random") : "R10 random"));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule